// File: doc/BRIEF.md
# Shadowed SRAM Recall and Store Controller

This block manages a small volatile memory that has a nonvolatile shadow copy. A recall rebuilds the volatile array from the shadow in two ordered passes: first every volatile word is forced to zero, then every shadow word is copied across. A store does the reverse and copies the volatile array into the shadow. Both arrays are small register arrays, and both passes handle one word per clock.

Supply state arrives as two digital comparator flags. `belowReset` reports a supply under the reset level. While it is high, any running recall or store is aborted and a recall request is held. The request is also set by reset, which models the first power-up. A held request launches a recall by itself once `aboveSwitch` reports a healthy supply. A store needs `aboveSwitch` as well: a store request made without it is dropped. A single-word read/write port serves the system between operations. It refuses every access while the controller is busy. If a write is still being driven in the cycle a recall finishes, that write collides with the freshly recalled data, and a sticky corruption flag is raised.

Top module: `nvsr_recall_top`

## Requirements
- R1: A recall keeps `busy` high for exactly 2*DEPTH cycles. All DEPTH volatile words are zeroed before the first shadow word is copied, one word per clock, in index order starting at word 0.
- R2: A recall never changes the shadow array, so back-to-back recalls return the same stored contents.
- R3: While `busy` is high, `accGrant` stays low. A write has no effect on the volatile array, and `accRdata` does not change.
- R4: Reset, and any cycle with `belowReset` high, sets the pending recall request.
- R5: A pending request starts a recall (`busy` high after the next clock edge) as soon as `aboveSwitch` is high and `belowReset` is low. With `aboveSwitch` low, no recall starts.
- R6: A store request made while `aboveSwitch` is low is ignored: `busy` stays low and the shadow array keeps its contents.
- R7: An accepted store keeps `busy` high for DEPTH cycles and copies every volatile word into the shadow array.
- R8: `belowReset` going high during a recall or store aborts it at the next clock edge, with `busy` low afterwards. Words not yet written keep their current values, and the recall request is raised again.
- R9: The recall request is cleared only when a recall completes, so no further recall follows a completed one while supply stays good.
- R10: A write still asserted (`accEn` and `accWe` high) in the final cycle of a recall overwrites the addressed volatile word with `accWdata` and sets `corrupt`. `corrupt` is cleared when the next recall starts.
- R11: When idle, a granted write updates the addressed word at the clock edge. A granted read presents the addressed word on `accRdata` after the next clock edge and holds it until the next granted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, models first power application |
| belowReset | input | 1 | Supply is below the reset level |
| aboveSwitch | input | 1 | Supply is above the switch level |
| storeReq | input | 1 | Request a copy of the volatile array into the shadow array |
| accEn | input | 1 | Access request on the read/write port |
| accWe | input | 1 | Access is a write when high, a read when low |
| accAddr | input | ADDR_W | Word address of the access |
| accWdata | input | DATA_W | Write data |
| accRdata | output | DATA_W | Registered read data |
| accGrant | output | 1 | Access accepted this cycle |
| busy | output | 1 | Recall or store in progress |
| corrupt | output | 1 | A write collided with the end of a recall |

## Verification
Several properties are checked on every cycle. A supply drop always leaves the controller idle one edge later. The copy pass only ever follows a complete clear pass. The shadow array is frozen during recall passes. A held request with good supply always launches a recall. The request only falls at a recall's final step. Read data is frozen while busy. The bench scenarios are needed for the end-to-end content results. These cover restored data after store and recall, the partial clear-then-copy image an aborted recall leaves, a store dropped under low supply, exact busy durations, and the collision write with its corruption flag.

// File: rtl/nvsr_pkg.sv
package nvsr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_COPY  = 2'd2,
    ST_STORE = 2'd3
  } nvsrState_e;

  typedef struct packed {
    logic clrWe;       // zero the volatile word at walk index
    logic cpyWe;       // shadow word -> volatile word at walk index
    logic nvWe;        // volatile word -> shadow word at walk index
    logic accWr;       // granted port write
    logic accRd;       // granted port read
    logic lateWr;      // write colliding with recall completion
    logic recallStart; // recall launched this cycle
  } nvsrStrobe_t;

endpackage

// File: rtl/nvsr_ctrl.sv
module nvsr_ctrl
  import nvsr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              belowReset,
  input  logic              aboveSwitch,
  input  logic              storeReq,
  input  logic              accEn,
  input  logic              accWe,
  output nvsrStrobe_t       strb,
  output logic [ADDR_W-1:0] walkIdx,
  output logic              accGrant,
  output logic              busy,
  output logic              corrupt
);

  localparam logic [ADDR_W-1:0] LAST_IDX = {ADDR_W{1'b1}};

  nvsrState_e        state, stateNxt;
  logic [ADDR_W-1:0] idx, idxNxt;
  logic              pending;
  logic              lastWord;
  logic              recallDone;

  assign lastWord = (idx == LAST_IDX);
  assign busy     = (state != ST_IDLE);
  assign walkIdx  = idx;
  assign accGrant = accEn && (state == ST_IDLE);

  always_comb begin
    stateNxt   = state;
    idxNxt     = idx;
    strb       = '0;
    recallDone = 1'b0;
    strb.accWr = accGrant && accWe;
    strb.accRd = accGrant && !accWe;
    if (belowReset) begin
      stateNxt = ST_IDLE;
      idxNxt   = '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pending && aboveSwitch) begin
            stateNxt         = ST_CLEAR;
            idxNxt           = '0;
            strb.recallStart = 1'b1;
          end else if (storeReq && aboveSwitch) begin
            stateNxt = ST_STORE;
            idxNxt   = '0;
          end
        end
        ST_CLEAR: begin
          strb.clrWe = 1'b1;
          if (lastWord) begin
            stateNxt = ST_COPY;
            idxNxt   = '0;
          end else begin
            idxNxt = idx + 1'b1;
          end
        end
        ST_COPY: begin
          strb.cpyWe = 1'b1;
          if (lastWord) begin
            stateNxt    = ST_IDLE;
            idxNxt      = '0;
            recallDone  = 1'b1;
            strb.lateWr = accEn && accWe;
          end else begin
            idxNxt = idx + 1'b1;
          end
        end
        ST_STORE: begin
          if (!aboveSwitch) begin
            stateNxt = ST_IDLE;
            idxNxt   = '0;
          end else begin
            strb.nvWe = 1'b1;
            if (lastWord) begin
              stateNxt = ST_IDLE;
              idxNxt   = '0;
            end else begin
              idxNxt = idx + 1'b1;
            end
          end
        end
        default: begin
          stateNxt = ST_IDLE;
          idxNxt   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      idx     <= '0;
      pending <= 1'b1;
      corrupt <= 1'b0;
    end else begin
      state <= stateNxt;
      idx   <= idxNxt;
      if (belowReset)      pending <= 1'b1;
      else if (recallDone) pending <= 1'b0;
      if (strb.recallStart) corrupt <= 1'b0;
      else if (strb.lateWr) corrupt <= 1'b1;
    end
  end

  // R8
  supply_drop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    belowReset |=> !busy);

  // R9
  request_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pending) |-> ($past(state) == ST_COPY) && ($past(idx) == LAST_IDX));

  // R5
  auto_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && aboveSwitch && !belowReset && !busy) |=> (state == ST_CLEAR));

  // R6
  store_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!aboveSwitch && (state != ST_STORE)) |=> (state != ST_STORE));

endmodule

// File: rtl/nvsr_datapath.sv
module nvsr_datapath
  import nvsr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvsrStrobe_t       strb,
  input  logic [ADDR_W-1:0] walkIdx,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWdata,
  output logic [DATA_W-1:0] accRdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] sramArr [DEPTH];
  logic [DATA_W-1:0] nvArr   [DEPTH];
  logic [DEPTH*DATA_W-1:0] nvFlat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign nvFlat[g*DATA_W +: DATA_W] = nvArr[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sramArr[g] <= '0;
        nvArr[g]   <= '0;
      end else begin
        if (strb.clrWe && (walkIdx == ADDR_W'(g))) sramArr[g] <= '0;
        if (strb.cpyWe && (walkIdx == ADDR_W'(g))) sramArr[g] <= nvArr[g];
        if ((strb.accWr || strb.lateWr) && (accAddr == ADDR_W'(g)))
          sramArr[g] <= accWdata;
        if (strb.nvWe && (walkIdx == ADDR_W'(g))) nvArr[g] <= sramArr[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          accRdata <= '0;
    else if (strb.accRd) accRdata <= sramArr[accAddr];
  end

  // R1
  copy_after_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.cpyWe) |-> $past(strb.clrWe) && ($past(walkIdx) == {ADDR_W{1'b1}}));

  // R2
  shadow_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrWe || strb.cpyWe) |=> $stable(nvFlat));

endmodule

// File: rtl/nvsr_recall_top.sv
module nvsr_recall_top
  import nvsr_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              belowReset,
  input  logic              aboveSwitch,
  input  logic              storeReq,
  input  logic              accEn,
  input  logic              accWe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [DATA_W-1:0] accWdata,
  output logic [DATA_W-1:0] accRdata,
  output logic              accGrant,
  output logic              busy,
  output logic              corrupt
);

  nvsrStrobe_t       strb;
  logic [ADDR_W-1:0] walkIdx;

  nvsr_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .belowReset  (belowReset),
    .aboveSwitch (aboveSwitch),
    .storeReq    (storeReq),
    .accEn       (accEn),
    .accWe       (accWe),
    .strb        (strb),
    .walkIdx     (walkIdx),
    .accGrant    (accGrant),
    .busy        (busy),
    .corrupt     (corrupt)
  );

  nvsr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .walkIdx  (walkIdx),
    .accAddr  (accAddr),
    .accWdata (accWdata),
    .accRdata (accRdata)
  );

  // R3
  busy_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(accRdata));

endmodule

// File: tb/test_nvsr_recall_top.sv
`timescale 1ns/1ps
module test_nvsr_recall_top;

  localparam int AW    = 3;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  localparam logic [DW-1:0] PAT [DEPTH] = '{8'h5A, 8'hA7, 8'h3C, 8'hE1, 8'h96, 8'h0F, 8'h71, 8'hC8};

  logic clk = 1'b0;
  logic rstN, belowReset, aboveSwitch, storeReq, accEn, accWe;
  logic [AW-1:0] accAddr;
  logic [DW-1:0] accWdata, accRdata;
  logic accGrant, busy, corrupt;

  int nChk = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  nvsr_recall_top #(.ADDR_W(AW), .DATA_W(DW)) i_nvsr_recall_top (
    .clk(clk), .rstN(rstN), .belowReset(belowReset), .aboveSwitch(aboveSwitch),
    .storeReq(storeReq), .accEn(accEn), .accWe(accWe), .accAddr(accAddr),
    .accWdata(accWdata), .accRdata(accRdata), .accGrant(accGrant),
    .busy(busy), .corrupt(corrupt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    accEn = 1'b1; accWe = 1'b1; accAddr = a; accWdata = d;
    @(negedge clk);
    accEn = 1'b0; accWe = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    accEn = 1'b1; accWe = 1'b0; accAddr = a;
    @(negedge clk);
    accEn = 1'b0;
    d = accRdata;
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic brownout();
    belowReset = 1'b1;
    @(negedge clk);
    belowReset = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int n;
    rstN = 1'b0; belowReset = 1'b1; aboveSwitch = 1'b0; storeReq = 1'b0;
    accEn = 1'b0; accWe = 1'b0; accAddr = '0; accWdata = '0;
    repeat (3) @(negedge clk);
    chk("reset busy", busy, 0);
    chk("reset corrupt", corrupt, 0);
    chk("reset rdata", accRdata, 0);
    rstN = 1'b1;
    @(negedge clk);
    belowReset = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 no start while aboveSwitch low", busy, 0);
    aboveSwitch = 1'b1;
    @(negedge clk);
    chk("R4 R5 power-up request starts recall", busy, 1);
    busyLen(n);
    chk("R1 recall length 2*DEPTH", n, 2 * DEPTH);

    // vector walk: write then read back every word (R11)
    for (int i = 0; i < DEPTH; i++) wr(AW'(i), PAT[i]);
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), d);
      chk("R11 idle read-after-write", d, PAT[i]);
    end

    // R9: no further recall once completed
    repeat (20) @(negedge clk);
    chk("R9 request cleared after completion", busy, 0);

    // R7 store
    storeReq = 1'b1;
    @(negedge clk);
    storeReq = 1'b0;
    chk("R7 store starts", busy, 1);
    busyLen(n);
    chk("R7 store length DEPTH", n, DEPTH);

    // R6 store while supply low is dropped
    wr(3'd4, 8'h11);
    aboveSwitch = 1'b0;
    storeReq = 1'b1;
    @(negedge clk);
    storeReq = 1'b0;
    chk("R6 store ignored busy", busy, 0);
    aboveSwitch = 1'b1;
    @(negedge clk);

    // recall restores stored image; access refused while busy (R3)
    brownout();
    chk("R4 brownout relaunches recall", busy, 1);
    rd(3'd6, d);
    chk("R3 rdata stable while busy", d, PAT[DEPTH-1]);
    accEn = 1'b1; accWe = 1'b1; accAddr = 3'd3; accWdata = 8'hEE;
    #1;
    chk("R3 grant low while busy", accGrant, 0);
    @(negedge clk);
    accEn = 1'b0; accWe = 1'b0;
    busyLen(n);
    rd(3'd4, d);
    chk("R6 shadow kept old word", d, PAT[4]);
    rd(3'd3, d);
    chk("R3 write while busy had no effect", d, PAT[3]);
    chk("R10 corrupt low after clean recall", corrupt, 0);

    // R2 repeat recall, same image
    brownout();
    busyLen(n);
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), d);
      chk("R2 repeated recall image", d, PAT[i]);
    end

    // R8 abort during copy pass: words 0,1 copied, rest cleared
    belowReset = 1'b1;
    @(negedge clk);
    belowReset = 1'b0;
    repeat (11) @(negedge clk);
    belowReset = 1'b1;
    @(negedge clk);
    chk("R8 abort drops busy", busy, 0);
    rd(3'd0, d);  chk("R8 copied word 0", d, PAT[0]);
    rd(3'd1, d);  chk("R8 copied word 1", d, PAT[1]);
    rd(3'd2, d);  chk("R1 uncopied word cleared", d, 0);
    rd(3'd5, d);  chk("R1 uncopied word 5 cleared", d, 0);
    belowReset = 1'b0;
    @(negedge clk);
    chk("R8 request relatched restarts recall", busy, 1);
    busyLen(n);
    chk("R8 restarted recall length", n, 2 * DEPTH);
    rd(3'd5, d);  chk("R8 word 5 after restart", d, PAT[5]);

    // R10 write held through recall completion
    accEn = 1'b1; accWe = 1'b1; accAddr = 3'd2; accWdata = 8'hC3;
    brownout();
    busyLen(n);
    accEn = 1'b0; accWe = 1'b0;
    chk("R10 corrupt raised", corrupt, 1);
    rd(3'd2, d);  chk("R10 colliding write data", d, 8'hC3);
    brownout();
    chk("R10 corrupt cleared at recall start", corrupt, 0);
    busyLen(n);
    rd(3'd2, d);  chk("R10 clean recall restores word", d, PAT[2]);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule